// File: doc/BRIEF.md
# Store Buffer with Load Forwarding

This block sits between one in-order core and a single-port memory. Stores committed by the core are parked in a small circular queue and written to memory in the background, oldest first, whenever the memory port is free. The core does not wait for a store to reach memory.

Loads are never held behind buffered stores. Each load address is compared with every occupied queue entry. On a hit the youngest matching entry supplies the data and memory is not touched. On a miss the load takes the memory port ahead of any store waiting to drain, so it can overtake older stores to other addresses. The result is that accesses to the same address stay in program order while accesses to different addresses may be reordered.

A fence request blocks new loads and stores until the queue has emptied, then reports completion with a one-cycle pulse. Load responses return strictly in acceptance order: forwarded loads answer on the next cycle and memory loads answer after the memory's fixed read latency.

Top module: `sbuf_fwd`

## Requirements
- R1: A store is accepted in a cycle where `st_valid_i` and `st_ready_o` are both high. `st_ready_o` is low whenever DEPTH stores are buffered, or a fence is requested or pending.
- R2: Buffered stores go to memory in acceptance order as write requests (`mem_req_o`=1, `mem_we_o`=1) carrying the entry's address and data. An entry is retired only in a cycle where `mem_gnt_i` is high.
- R3: When a load is presented, is not stalled and matches no buffered store, the memory request in that cycle is a read (`mem_we_o`=0) of the load address, even if a store is waiting to drain. The load is accepted in exactly the cycles where `mem_gnt_i` is high.
- R4: The load address is compared with every occupied entry. On a match, no memory read is issued for that load.
- R5: When several entries match, the forwarded data comes from the most recently accepted of them.
- R6: A load returns the value of the latest store to its address that was accepted in an earlier cycle, or the memory contents if there is none. A store accepted in the same cycle as a load counts as younger than that load.
- R7: A forwarded load asserts `ld_rvalid_o` exactly one cycle after it is accepted. It is accepted only when no memory read is outstanding.
- R8: A memory load asserts `ld_rvalid_o` in the cycle the memory returns `mem_rvalid_i`, which comes RD_LAT cycles after the read was granted. Responses never overlap and come back in acceptance order.
- R9: A one-cycle pulse on `fence_i` stalls loads and stores from that cycle onward. `fence_done_o` pulses for one cycle in the first cycle where the fence is pending and the queue is empty, and this also ends the stall. A `fence_i` pulse that arrives while a fence is pending has no effect.
- R10: While `rst_ni` is low, and in the first cycle after it rises, the queue is empty: `st_ready_o`=1, `mem_req_o`=0, `ld_rvalid_o`=0 and `fence_done_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| st_valid_i | input | 1 | Store request |
| st_ready_o | output | 1 | Store can be accepted |
| st_addr_i | input | AW | Store address |
| st_data_i | input | DW | Store data |
| ld_valid_i | input | 1 | Load request |
| ld_ready_o | output | 1 | Load accepted this cycle |
| ld_addr_i | input | AW | Load address |
| ld_rvalid_o | output | 1 | Load response valid |
| ld_rdata_o | output | DW | Load response data |
| fence_i | input | 1 | Fence request pulse |
| fence_done_o | output | 1 | Fence complete pulse |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | AW | Memory address |
| mem_wdata_o | output | DW | Memory write data |
| mem_gnt_i | input | 1 | Memory accepts the request |
| mem_rvalid_i | input | 1 | Memory read data valid |
| mem_rdata_i | input | DW | Memory read data |

## Verification
Each result has its own due time. Request-side results are due in the same cycle as the stimulus: `st_ready_o`, `ld_ready_o`, the memory request fields and `fence_done_o` are all combinational on the current inputs and on state registered at the previous edge. A forwarded load's response is due one edge after its acceptance. A memory load's response is due in the cycle the memory model raises `mem_rvalid_i`, RD_LAT edges after the grant. The bench records every accepted load with its due cycle and its expected data, drives inputs just after each rising edge and compares all outputs at the falling edge of that same cycle. As a result, an early, late or missing response shows up as a mismatch in exactly one cycle.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;
  typedef enum logic [1:0] {
    SEL_IDLE  = 2'd0,
    SEL_LOAD  = 2'd1,
    SEL_STORE = 2'd2
  } port_sel_e;
endpackage

// File: rtl/sbuf_store_q.sv
module sbuf_store_q #(
  parameter int DEPTH = 4,
  parameter int AW    = 8,
  parameter int DW    = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [AW-1:0] push_addr_i,
  input  logic [DW-1:0] push_data_i,
  input  logic          pop_i,
  input  logic [AW-1:0] lkp_addr_i,
  output logic          hit_o,
  output logic [DW-1:0] hit_data_o,
  output logic          head_valid_o,
  output logic [AW-1:0] head_addr_o,
  output logic [DW-1:0] head_data_o,
  output logic          full_o,
  output logic          empty_o
);
  timeunit 1ns; timeprecision 100ps;

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int IW    = PTR_W + 1;

  logic [AW-1:0]    addr_q [DEPTH];
  logic [DW-1:0]    data_q [DEPTH];
  logic [DEPTH-1:0] valid_q;
  logic [PTR_W-1:0] head_q, tail_q;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    if (p == PTR_W'(DEPTH - 1)) return '0;
    return p + 1'b1;
  endfunction

  assign full_o       = valid_q[tail_q];
  assign head_valid_o = valid_q[head_q];
  assign empty_o      = ~valid_q[head_q];
  assign head_addr_o  = addr_q[head_q];
  assign head_data_o  = data_q[head_q];

  // scan oldest to youngest so the last match wins
  always_comb begin
    logic [IW-1:0] s;
    hit_o      = 1'b0;
    hit_data_o = '0;
    for (int k = 0; k < DEPTH; k++) begin
      s = IW'(head_q) + IW'(k);
      if (s >= IW'(DEPTH)) s = s - IW'(DEPTH);
      if (valid_q[s[PTR_W-1:0]] && addr_q[s[PTR_W-1:0]] == lkp_addr_i) begin
        hit_o      = 1'b1;
        hit_data_o = data_q[s[PTR_W-1:0]];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      head_q  <= '0;
      tail_q  <= '0;
    end else begin
      if (push_i) begin
        valid_q[tail_q] <= 1'b1;
        tail_q          <= ptr_inc(tail_q);
      end
      if (pop_i) begin
        valid_q[head_q] <= 1'b0;
        head_q          <= ptr_inc(head_q);
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) begin
      addr_q[tail_q] <= push_addr_i;
      data_q[tail_q] <= push_data_i;
    end
  end

  assert_push_not_full_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  assert_pop_nonempty_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> head_valid_o);
endmodule

// File: rtl/sbuf_port_arb.sv
module sbuf_port_arb
  import sbuf_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic          ld_req_i,
  input  logic [AW-1:0] ld_addr_i,
  input  logic          st_req_i,
  input  logic [AW-1:0] st_addr_i,
  input  logic [DW-1:0] st_data_i,
  input  logic          mem_gnt_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic          ld_go_o,
  output logic          st_go_o
);
  timeunit 1ns; timeprecision 100ps;

  port_sel_e sel;

  // load misses outrank draining stores
  always_comb begin
    sel = SEL_IDLE;
    if (ld_req_i)      sel = SEL_LOAD;
    else if (st_req_i) sel = SEL_STORE;
  end

  assign mem_req_o   = (sel != SEL_IDLE);
  assign mem_we_o    = (sel == SEL_STORE);
  assign mem_addr_o  = (sel == SEL_STORE) ? st_addr_i : ld_addr_i;
  assign mem_wdata_o = st_data_i;
  assign ld_go_o     = (sel == SEL_LOAD) && mem_gnt_i;
  assign st_go_o     = (sel == SEL_STORE) && mem_gnt_i;
endmodule

// File: rtl/sbuf_ld_resp.sv
module sbuf_ld_resp #(
  parameter int DW     = 32,
  parameter int RD_LAT = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fwd_go_i,
  input  logic [DW-1:0] fwd_data_i,
  input  logic          mem_go_i,
  input  logic          mem_rvalid_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          idle_o,
  output logic          rvalid_o,
  output logic [DW-1:0] rdata_o
);
  timeunit 1ns; timeprecision 100ps;

  localparam int CW = $clog2(RD_LAT + 2);

  logic [CW-1:0] inflight_q;
  logic          fwd_vld_q;
  logic [DW-1:0] fwd_data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      inflight_q <= '0;
      fwd_vld_q  <= 1'b0;
      fwd_data_q <= '0;
    end else begin
      inflight_q <= inflight_q + CW'(mem_go_i) - CW'(mem_rvalid_i);
      fwd_vld_q  <= fwd_go_i;
      if (fwd_go_i) fwd_data_q <= fwd_data_i;
    end
  end

  assign idle_o   = (inflight_q == '0);
  assign rvalid_o = fwd_vld_q | mem_rvalid_i;
  assign rdata_o  = fwd_vld_q ? fwd_data_q : mem_rdata_i;

  assert_rvalid_owed_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rvalid_i |-> !idle_o);
  assert_no_collide_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fwd_vld_q && mem_rvalid_i));
  assert_fwd_next_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fwd_go_i |=> rvalid_o && !mem_rvalid_i);
endmodule

// File: rtl/sbuf_fwd.sv
module sbuf_fwd #(
  parameter int DEPTH  = 4,
  parameter int AW     = 8,
  parameter int DW     = 32,
  parameter int RD_LAT = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          st_valid_i,
  output logic          st_ready_o,
  input  logic [AW-1:0] st_addr_i,
  input  logic [DW-1:0] st_data_i,
  input  logic          ld_valid_i,
  output logic          ld_ready_o,
  input  logic [AW-1:0] ld_addr_i,
  output logic          ld_rvalid_o,
  output logic [DW-1:0] ld_rdata_o,
  input  logic          fence_i,
  output logic          fence_done_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic          mem_gnt_i,
  input  logic          mem_rvalid_i,
  input  logic [DW-1:0] mem_rdata_i
);
  timeunit 1ns; timeprecision 100ps;

  logic          stall, push, pop, full, empty;
  logic          ld_hit, ld_miss_req, fwd_go, ld_go, mem_idle;
  logic [DW-1:0] hit_data;
  logic          head_valid;
  logic [AW-1:0] head_addr;
  logic [DW-1:0] head_data;
  logic          fence_pend_q;

  assign stall       = fence_i | fence_pend_q;
  assign st_ready_o  = ~full & ~stall;
  assign push        = st_valid_i & st_ready_o;
  assign ld_miss_req = ld_valid_i & ~ld_hit & ~stall;
  // forwarding waits for older memory reads to keep responses ordered
  assign fwd_go      = ld_valid_i & ld_hit & ~stall & mem_idle;
  assign ld_ready_o  = ~stall & (ld_hit ? mem_idle : mem_gnt_i);

  sbuf_store_q #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_q (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .push_i       (push),
    .push_addr_i  (st_addr_i),
    .push_data_i  (st_data_i),
    .pop_i        (pop),
    .lkp_addr_i   (ld_addr_i),
    .hit_o        (ld_hit),
    .hit_data_o   (hit_data),
    .head_valid_o (head_valid),
    .head_addr_o  (head_addr),
    .head_data_o  (head_data),
    .full_o       (full),
    .empty_o      (empty)
  );

  sbuf_port_arb #(.AW(AW), .DW(DW)) u_arb (
    .ld_req_i    (ld_miss_req),
    .ld_addr_i   (ld_addr_i),
    .st_req_i    (head_valid),
    .st_addr_i   (head_addr),
    .st_data_i   (head_data),
    .mem_gnt_i   (mem_gnt_i),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .ld_go_o     (ld_go),
    .st_go_o     (pop)
  );

  sbuf_ld_resp #(.DW(DW), .RD_LAT(RD_LAT)) u_resp (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .fwd_go_i     (fwd_go),
    .fwd_data_i   (hit_data),
    .mem_go_i     (ld_go),
    .mem_rvalid_i (mem_rvalid_i),
    .mem_rdata_i  (mem_rdata_i),
    .idle_o       (mem_idle),
    .rvalid_o     (ld_rvalid_o),
    .rdata_o      (ld_rdata_o)
  );

  assign fence_done_o = fence_pend_q & empty;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           fence_pend_q <= 1'b0;
    else if (fence_done_o) fence_pend_q <= 1'b0;
    else if (fence_i)      fence_pend_q <= 1'b1;
  end

  assert_ld_priority_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_valid_i && !ld_hit && !stall) |-> (mem_req_o && !mem_we_o && mem_addr_o == ld_addr_i));
  assert_hit_no_read_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_valid_i && ld_hit) |-> !(mem_req_o && !mem_we_o));
  assert_fence_drained_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fence_done_o |-> !(mem_req_o && mem_we_o) && !st_ready_o);
  assert_fence_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fence_done_o |=> !fence_done_o);
endmodule

// File: tb/sbuf_fwd_bench.sv
module sbuf_fwd_bench;
  timeunit 1ns; timeprecision 100ps;

  localparam int DEPTH  = 4;
  localparam int AW     = 4;
  localparam int DW     = 16;
  localparam int RD_LAT = 3;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic st_valid_i = 1'b0, ld_valid_i = 1'b0, fence_i = 1'b0;
  logic [AW-1:0] st_addr_i = '0, ld_addr_i = '0;
  logic [DW-1:0] st_data_i = '0, mem_rdata_i = '0;
  logic mem_gnt_i = 1'b0, mem_rvalid_i = 1'b0;
  logic st_ready_o, ld_ready_o, ld_rvalid_o, fence_done_o;
  logic mem_req_o, mem_we_o;
  logic [AW-1:0] mem_addr_o;
  logic [DW-1:0] ld_rdata_o, mem_wdata_o;

  always #2.5 clk_i = ~clk_i;

  sbuf_fwd #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .RD_LAT(RD_LAT)) u_sbuf_fwd (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .st_valid_i(st_valid_i), .st_ready_o(st_ready_o), .st_addr_i(st_addr_i), .st_data_i(st_data_i),
    .ld_valid_i(ld_valid_i), .ld_ready_o(ld_ready_o), .ld_addr_i(ld_addr_i),
    .ld_rvalid_o(ld_rvalid_o), .ld_rdata_o(ld_rdata_o),
    .fence_i(fence_i), .fence_done_o(fence_done_o),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
    .mem_gnt_i(mem_gnt_i), .mem_rvalid_i(mem_rvalid_i), .mem_rdata_i(mem_rdata_i)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;
  int st_pct = 0, ld_pct = 0, gnt_pct = 0, fc_pct = 0, amax = 16;

  logic [DW-1:0] arch [2**AW];
  logic [DW-1:0] mem_arr [2**AW];
  logic [AW-1:0] q_addr [$];
  logic [DW-1:0] q_data [$];
  int            rd_due [$];
  logic [DW-1:0] rd_data [$];
  int            ex_due [$];
  logic [DW-1:0] ex_data [$];
  bit            ex_fwd [$];
  bit fence_pend_m = 0, st_hold = 0, ld_hold = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s cyc=%0d actual=%0h expected=%0h", tag, cyc, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < 2**AW; i++) begin arch[i] = '0; mem_arr[i] = '0; end
  end

  // reset state, during and after reset (R10)
  initial begin
    repeat (3) @(negedge clk_i);
    chk(st_ready_o == 1'b1 && mem_req_o == 1'b0, "R10 in-reset ready/req", {st_ready_o, mem_req_o}, 2'b10);
    chk(ld_rvalid_o == 1'b0 && fence_done_o == 1'b0, "R10 in-reset rvalid/done", {ld_rvalid_o, fence_done_o}, 2'b00);
    @(posedge clk_i); #1 rst_ni = 1'b1;
    @(negedge clk_i);
    chk(st_ready_o == 1'b1 && mem_req_o == 1'b0, "R10 post-reset ready/req", {st_ready_o, mem_req_o}, 2'b10);
    chk(ld_rvalid_o == 1'b0 && fence_done_o == 1'b0, "R10 post-reset rvalid/done", {ld_rvalid_o, fence_done_o}, 2'b00);
  end

  // cycle driver and reference model
  initial begin
    wait (rst_ni);
    forever begin
      bit hit, stall, idle, exp_rv, ld_miss, exp_done;
      logic [DW-1:0] hdata;
      @(posedge clk_i); cyc++; #1;
      mem_gnt_i    = ($urandom % 100) < gnt_pct;
      mem_rvalid_i = (rd_due.size() > 0 && rd_due[0] == cyc);
      mem_rdata_i  = mem_rvalid_i ? rd_data[0] : '0;
      if (!st_hold) begin
        st_valid_i = 1'b0;
        if (($urandom % 100) < st_pct) begin
          st_valid_i = 1'b1; st_addr_i = AW'($urandom % amax); st_data_i = DW'($urandom); st_hold = 1;
        end
      end
      if (!ld_hold) begin
        ld_valid_i = 1'b0;
        if (($urandom % 100) < ld_pct) begin
          ld_valid_i = 1'b1; ld_addr_i = AW'($urandom % amax); ld_hold = 1;
        end
      end
      fence_i = !fence_pend_m && (($urandom % 100) < fc_pct);

      @(negedge clk_i);
      hit = 0; hdata = '0;
      foreach (q_addr[i]) if (q_addr[i] == ld_addr_i) begin hit = 1; hdata = q_data[i]; end
      stall   = fence_i || fence_pend_m;
      idle    = (rd_due.size() == 0);
      ld_miss = ld_valid_i && !hit && !stall;

      chk(st_ready_o == (!stall && q_addr.size() < DEPTH), "R1 st_ready", st_ready_o, !stall && q_addr.size() < DEPTH);
      if (ld_valid_i)
        chk(ld_ready_o == (!stall && (hit ? idle : mem_gnt_i)), hit ? "R7 fwd ld_ready" : "R3 miss ld_ready",
            ld_ready_o, !stall && (hit ? idle : mem_gnt_i));
      if (ld_miss)
        chk(mem_req_o && !mem_we_o && mem_addr_o == ld_addr_i, "R3 load read first",
            {mem_req_o, mem_we_o, mem_addr_o}, {2'b10, ld_addr_i});
      else if (ld_valid_i && hit)
        chk(!(mem_req_o && !mem_we_o), "R4 hit no read", {mem_req_o, mem_we_o}, 2'b01);
      if (!ld_miss && q_addr.size() > 0)
        chk(mem_req_o && mem_we_o && mem_addr_o == q_addr[0] && mem_wdata_o == q_data[0], "R2 drain head",
            {mem_req_o, mem_we_o, mem_addr_o, mem_wdata_o}, {2'b11, q_addr[0], q_data[0]});
      else if (!ld_miss)
        chk(!mem_req_o, "R2 idle port", mem_req_o, 0);

      exp_rv = (ex_due.size() > 0 && ex_due[0] == cyc);
      chk(ld_rvalid_o == exp_rv, (exp_rv && ex_fwd[0]) ? "R7 fwd resp timing" : "R8 mem resp timing", ld_rvalid_o, exp_rv);
      if (exp_rv) begin
        chk(ld_rdata_o == ex_data[0], ex_fwd[0] ? "R5 youngest fwd data" : "R6 memory load data", ld_rdata_o, ex_data[0]);
        void'(ex_due.pop_front()); void'(ex_data.pop_front()); void'(ex_fwd.pop_front());
      end
      exp_done = fence_pend_m && q_addr.size() == 0;
      chk(fence_done_o == exp_done, "R9 fence_done", fence_done_o, exp_done);

      if (ld_valid_i && ld_ready_o) begin
        if (hit) chk(hdata == arch[ld_addr_i], "R6 fwd equals latest store", hdata, arch[ld_addr_i]);
        ex_due.push_back(hit ? cyc + 1 : cyc + RD_LAT);
        ex_data.push_back(arch[ld_addr_i]);
        ex_fwd.push_back(hit);
        if (!hit) begin rd_due.push_back(cyc + RD_LAT); rd_data.push_back(mem_arr[ld_addr_i]); end
        ld_hold = 0;
      end
      if (mem_req_o && mem_we_o && mem_gnt_i && q_addr.size() > 0) begin
        mem_arr[mem_addr_o] = mem_wdata_o;
        void'(q_addr.pop_front()); void'(q_data.pop_front());
      end
      if (mem_rvalid_i) begin void'(rd_due.pop_front()); void'(rd_data.pop_front()); end
      if (st_valid_i && st_ready_o) begin
        q_addr.push_back(st_addr_i); q_data.push_back(st_data_i);
        arch[st_addr_i] = st_data_i;
        st_hold = 0;
      end
      if (exp_done) fence_pend_m = 0;
      else if (fence_i) fence_pend_m = 1;
    end
  end

  // phases
  initial begin
    wait (rst_ni);
    st_pct = 40; ld_pct = 40; gnt_pct = 60; fc_pct = 2; amax = 16;
    repeat (800) @(posedge clk_i);
    st_pct = 100; ld_pct = 0; gnt_pct = 0; fc_pct = 0; amax = 2;   // fill to full, same addresses (R1, R5)
    repeat (30) @(posedge clk_i);
    ld_pct = 100;                                                  // hits forward, misses wait
    repeat (60) @(posedge clk_i);
    st_pct = 60; ld_pct = 100; gnt_pct = 100; amax = 4;            // load priority over drain (R3)
    repeat (600) @(posedge clk_i);
    st_pct = 50; ld_pct = 30; gnt_pct = 30; fc_pct = 10; amax = 8; // fences (R9)
    repeat (800) @(posedge clk_i);
    st_pct = 50; ld_pct = 50; gnt_pct = 50; fc_pct = 1; amax = 3;
    repeat (3000) @(posedge clk_i);
    st_pct = 0; ld_pct = 0; gnt_pct = 100; fc_pct = 0;
    repeat (60) @(posedge clk_i);
    @(negedge clk_i);
    chk(q_addr.size() == 0 && mem_req_o == 1'b0, "R2 final drain", mem_req_o, 0);
    chk(ex_due.size() == 0, "R8 all responses delivered", ex_due.size(), 0);
    done = 1;
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired cyc=%0d actual=hung expected=done", cyc);
      finish_run();
    end
  end
endmodule